// File: doc/BRIEF.md
# Accumulator ALU with Instruction Decode

This block is the execute stage of a small 8-bit accumulator machine with 14-bit single-word instructions. It takes one instruction word together with the working register (W), the 8-bit operand fetched from the addressed file register, and the current carry, half-carry and zero flags. From these it decodes the operation, computes the 8-bit result, and chooses where the result goes: W or the file register. It also produces the new flag values and a skip request for the sequencer.

The operations covered are arithmetic, logic, rotate-through-carry, nibble swap, increment and decrement with or without skip-on-zero, moves and clears, and single-bit set, clear and test. Program flow, the stack and memory access belong to neighbouring blocks. Those blocks use `f_addr`, `wr_f`, `wr_w` and `skip` to commit the result.

The execute stage has one register stage. An instruction presented with `in_valid` high on one rising edge appears on the outputs after that edge.

Top module: `acc_alu`

## Requirements
- R1: For register-operand forms, bits 13:8 are the opcode, bit 7 is the destination (0 writes W, 1 writes the file register) and bits 6:0 are the file address, echoed on `f_addr`. The immediate forms always write W and take bits 7:0 as the immediate. At most one of `wr_w` and `wr_f` is high.
- R2: Opcode 011011 (register) and 110111 (immediate) add the operand to W. C is the carry out of bit 7, HC is the carry out of bit 3, and Z is set when the result is zero.
- R3: Opcode 011100 computes register + ~W + 1, and 111000 computes immediate + ~W + 1. C and HC are the carries out of bit 7 and bit 3 of that sum, so 1 means no borrow. Z marks a zero result.
- R4: The following operations update Z only; C and HC keep their input values:
  - AND: 010010, or 110100 with an immediate.
  - IOR: 010011, or 110101 with an immediate.
  - XOR: 010100, or 110110 with an immediate.
  - Complement: 011111.
  - Increment: 011001.
  - Decrement: 011101.
  - Load register: 011000.
  - Clear register: 010001 with bit 7 = 0. It always writes the file register.
  - Clear W: 010000 with bit 7 = 1.
- R5: Increment-skip (011010) and decrement-skip (011110) change no flag. They raise `skip` exactly when the 8-bit result is zero.
- R6: Rotate right (010110) shifts the old carry into bit 7 and bit 0 into C. Rotate left (010101) shifts the old carry into bit 0 and bit 7 into C. HC and Z are unchanged.
- R7: None of these change a flag:
  - Swap nibbles: 010111.
  - Store W to the file register: 010001 with bit 7 = 1.
  - Load immediate into W: 111010.
- R8: With bits 13:12 = 00, bits 9:7 select a bit and bits 11:10 select the action, none of which touches a flag:
  - 00 clears the selected bit of the operand and writes the file register.
  - 10 sets the selected bit and writes the file register.
  - 01 writes nothing and skips if the bit is 0.
  - 11 writes nothing and skips if the bit is 1.
- R9: Any other opcode writes nothing, requests no skip and passes the flags through. This includes 010000 with bit 7 = 0, all 10xxxx, 110000–110011, 111001 and 111011–111111.
- R10: Outputs update on the rising edge after `in_valid` is sampled high. After an edge with `in_valid` low, `out_valid`, `wr_w`, `wr_f` and `skip` are 0, and `result`, `f_addr` and the flags hold.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Addressed file register value |
| c_in | input | 1 | Current carry flag |
| hc_in | input | 1 | Current half-carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Registered outputs hold a new instruction |
| result | output | 8 | Computed value |
| f_addr | output | 7 | File address to write |
| wr_w | output | 1 | Write result to W |
| wr_f | output | 1 | Write result to the file register |
| c_out | output | 1 | New carry flag |
| hc_out | output | 1 | New half-carry flag |
| z_out | output | 1 | New zero flag |
| skip | output | 1 | Skip the next instruction |

## Verification
The hardest cases to reach are the ones where the carry and half-carry must move on their own:
- A half carry with no carry out of bit 7.
- A borrow from the upper nibble only.
- The zero-result corners of the skip-on-zero forms, which occur for only one operand value each.

Uniform random operands almost never hit these, so each arithmetic task first drives chosen pairs (0x0F+0x01, 0xFF+0x01, 0x10−0x01, equal operands, 0xFF and 0x01 into the skip forms) and then random pairs. For the single-bit forms, every bit index is walked against an operand that has only that bit set, and then against its complement.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int INSN_W = 14;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int OPC_W  = 6;
  localparam int NIB_W  = DATA_W / 2;
  localparam int BIT_W  = $clog2(DATA_W);

  typedef enum logic [4:0] {
    K_NONE, K_ADD, K_SUB, K_INC, K_DEC, K_INCSZ, K_DECSZ,
    K_AND, K_IOR, K_XOR, K_COM, K_RRC, K_RLC, K_SWAP,
    K_MOVF, K_CLR, K_STW, K_LDI, K_BCLR, K_BSET, K_BTC, K_BTS
  } op_kind_e;

  typedef struct packed {
    op_kind_e         kind;
    logic             use_imm;
    logic             to_w;
    logic             to_f;
    logic             upd_c;
    logic             upd_hc;
    logic             upd_z;
    logic [BIT_W-1:0] bitsel;
  } dec_t;

  // Returns {carry out of top bit, carry out of low nibble, sum}.
  function automatic logic [DATA_W+1:0] add_split(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic              cin
  );
    logic [NIB_W:0]          lo;
    logic [DATA_W-NIB_W:0]   hi;
    lo = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    hi = {1'b0, a[DATA_W-1:NIB_W]} + {1'b0, b[DATA_W-1:NIB_W]}
         + {{(DATA_W-NIB_W){1'b0}}, lo[NIB_W]};
    return {hi[DATA_W-NIB_W], lo[NIB_W], hi[DATA_W-NIB_W-1:0], lo[NIB_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] swap_nib(input logic [DATA_W-1:0] a);
    return {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
  endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [INSN_W-1:ADDR_W] op_hi,
  output dec_t                   dec
);
  localparam int TOP = INSN_W - 1;

  logic [OPC_W-1:0] opc;
  logic             dst;
  logic             reg_dst;

  assign opc = op_hi[TOP:ADDR_W+1];
  assign dst = op_hi[ADDR_W];

  always_comb begin
    dec         = '0;
    dec.kind    = K_NONE;
    dec.bitsel  = op_hi[ADDR_W+BIT_W-1:ADDR_W];
    reg_dst     = 1'b0;
    if (op_hi[TOP:TOP-1] == 2'b00) begin
      unique case (op_hi[TOP-2:TOP-3])
        2'b00:   begin dec.kind = K_BCLR; dec.to_f = 1'b1; end
        2'b10:   begin dec.kind = K_BSET; dec.to_f = 1'b1; end
        2'b01:   dec.kind = K_BTC;
        default: dec.kind = K_BTS;
      endcase
    end else begin
      case (opc)
        6'b011011: begin dec.kind = K_ADD;   reg_dst = 1'b1;
                         dec.upd_c = 1'b1; dec.upd_hc = 1'b1; dec.upd_z = 1'b1; end
        6'b011100: begin dec.kind = K_SUB;   reg_dst = 1'b1;
                         dec.upd_c = 1'b1; dec.upd_hc = 1'b1; dec.upd_z = 1'b1; end
        6'b011001: begin dec.kind = K_INC;   reg_dst = 1'b1; dec.upd_z = 1'b1; end
        6'b011010: begin dec.kind = K_INCSZ; reg_dst = 1'b1; end
        6'b011101: begin dec.kind = K_DEC;   reg_dst = 1'b1; dec.upd_z = 1'b1; end
        6'b011110: begin dec.kind = K_DECSZ; reg_dst = 1'b1; end
        6'b010010: begin dec.kind = K_AND;   reg_dst = 1'b1; dec.upd_z = 1'b1; end
        6'b010011: begin dec.kind = K_IOR;   reg_dst = 1'b1; dec.upd_z = 1'b1; end
        6'b010100: begin dec.kind = K_XOR;   reg_dst = 1'b1; dec.upd_z = 1'b1; end
        6'b011111: begin dec.kind = K_COM;   reg_dst = 1'b1; dec.upd_z = 1'b1; end
        6'b010110: begin dec.kind = K_RRC;   reg_dst = 1'b1; dec.upd_c = 1'b1; end
        6'b010101: begin dec.kind = K_RLC;   reg_dst = 1'b1; dec.upd_c = 1'b1; end
        6'b010111: begin dec.kind = K_SWAP;  reg_dst = 1'b1; end
        6'b011000: begin dec.kind = K_MOVF;  reg_dst = 1'b1; dec.upd_z = 1'b1; end
        6'b010001: begin
          dec.to_f = 1'b1;
          if (dst) dec.kind = K_STW;
          else begin dec.kind = K_CLR; dec.upd_z = 1'b1; end
        end
        6'b010000: begin
          if (dst) begin dec.kind = K_CLR; dec.to_w = 1'b1; dec.upd_z = 1'b1; end
        end
        6'b110111: begin dec.kind = K_ADD; dec.use_imm = 1'b1; dec.to_w = 1'b1;
                         dec.upd_c = 1'b1; dec.upd_hc = 1'b1; dec.upd_z = 1'b1; end
        6'b111000: begin dec.kind = K_SUB; dec.use_imm = 1'b1; dec.to_w = 1'b1;
                         dec.upd_c = 1'b1; dec.upd_hc = 1'b1; dec.upd_z = 1'b1; end
        6'b110100: begin dec.kind = K_AND; dec.use_imm = 1'b1; dec.to_w = 1'b1;
                         dec.upd_z = 1'b1; end
        6'b110101: begin dec.kind = K_IOR; dec.use_imm = 1'b1; dec.to_w = 1'b1;
                         dec.upd_z = 1'b1; end
        6'b110110: begin dec.kind = K_XOR; dec.use_imm = 1'b1; dec.to_w = 1'b1;
                         dec.upd_z = 1'b1; end
        6'b111010: begin dec.kind = K_LDI; dec.use_imm = 1'b1; dec.to_w = 1'b1; end
        default:   dec.kind = K_NONE;
      endcase
      if (reg_dst) begin
        dec.to_w = ~dst;
        dec.to_f = dst;
      end
    end
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
(
  input  op_kind_e          kind,
  input  logic [BIT_W-1:0]  bitsel,
  input  logic [DATA_W-1:0] w_val,
  input  logic [DATA_W-1:0] opnd,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_new,
  output logic              hc_new,
  output logic              bit_hit
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W+1:0] sum_add;
  logic [DATA_W+1:0] sum_sub;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (bitsel == BIT_W'(i));
  end

  assign sum_add = add_split(opnd, w_val, 1'b0);
  assign sum_sub = add_split(opnd, ~w_val, 1'b1);
  assign bit_hit = |(opnd & mask);

  always_comb begin
    res    = opnd;
    c_new  = c_in;
    hc_new = 1'b0;
    case (kind)
      K_ADD:           {c_new, hc_new, res} = sum_add;
      K_SUB:           {c_new, hc_new, res} = sum_sub;
      K_INC, K_INCSZ:  res = opnd + 1'b1;
      K_DEC, K_DECSZ:  res = opnd - 1'b1;
      K_AND:           res = opnd & w_val;
      K_IOR:           res = opnd | w_val;
      K_XOR:           res = opnd ^ w_val;
      K_COM:           res = ~opnd;
      K_RRC:           begin res = {c_in, opnd[DATA_W-1:1]}; c_new = opnd[0]; end
      K_RLC:           begin res = {opnd[DATA_W-2:0], c_in}; c_new = opnd[DATA_W-1]; end
      K_SWAP:          res = swap_nib(opnd);
      K_CLR:           res = '0;
      K_STW:           res = w_val;
      K_BCLR:          res = opnd & ~mask;
      K_BSET:          res = opnd | mask;
      default:         res = opnd;
    endcase
  end

endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
  import acc_alu_pkg::*;
(
  input  dec_t              dec,
  input  logic [DATA_W-1:0] res,
  input  logic              c_new,
  input  logic              hc_new,
  input  logic              bit_hit,
  input  logic              c_in,
  input  logic              hc_in,
  input  logic              z_in,
  output logic              c_o,
  output logic              hc_o,
  output logic              z_o,
  output logic              res_zero,
  output logic              skip_o
);
  assign res_zero = (res == '0);
  assign c_o  = dec.upd_c  ? c_new    : c_in;
  assign hc_o = dec.upd_hc ? hc_new   : hc_in;
  assign z_o  = dec.upd_z  ? res_zero : z_in;

  always_comb begin
    case (dec.kind)
      K_INCSZ, K_DECSZ: skip_o = res_zero;
      K_BTC:            skip_o = ~bit_hit;
      K_BTS:            skip_o = bit_hit;
      default:          skip_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] instr,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] f_in,
  input  logic              c_in,
  input  logic              hc_in,
  input  logic              z_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [ADDR_W-1:0] f_addr,
  output logic              wr_w,
  output logic              wr_f,
  output logic              c_out,
  output logic              hc_out,
  output logic              z_out,
  output logic              skip
);
  dec_t              dec;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] res_c;
  logic              c_new, hc_new, bit_hit;
  logic              c_nx, hc_nx, z_nx;
  logic              res_zero;
  logic              skip_req;

  acc_alu_decode u_dec (
    .op_hi (instr[INSN_W-1:ADDR_W]),
    .dec   (dec)
  );

  assign opnd = dec.use_imm ? instr[DATA_W-1:0] : f_in;

  acc_alu_datapath u_dp (
    .kind    (dec.kind),
    .bitsel  (dec.bitsel),
    .w_val   (w_in),
    .opnd    (opnd),
    .c_in    (c_in),
    .res     (res_c),
    .c_new   (c_new),
    .hc_new  (hc_new),
    .bit_hit (bit_hit)
  );

  acc_alu_cond u_cond (
    .dec      (dec),
    .res      (res_c),
    .c_new    (c_new),
    .hc_new   (hc_new),
    .bit_hit  (bit_hit),
    .c_in     (c_in),
    .hc_in    (hc_in),
    .z_in     (z_in),
    .c_o      (c_nx),
    .hc_o     (hc_nx),
    .z_o      (z_nx),
    .res_zero (res_zero),
    .skip_o   (skip_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      f_addr    <= '0;
      wr_w      <= 1'b0;
      wr_f      <= 1'b0;
      c_out     <= 1'b0;
      hc_out    <= 1'b0;
      z_out     <= 1'b0;
      skip      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_w      <= in_valid & dec.to_w;
      wr_f      <= in_valid & dec.to_f;
      skip      <= in_valid & skip_req;
      if (in_valid) begin
        result <= res_c;
        f_addr <= instr[ADDR_W-1:0];
        c_out  <= c_nx;
        hc_out <= hc_nx;
        z_out  <= z_nx;
      end
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] instr,
  input logic              c_in,
  input logic              hc_in,
  input logic              z_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              wr_w,
  input logic              wr_f,
  input logic              c_out,
  input logic              hc_out,
  input logic              z_out,
  input logic              skip,
  input logic              res_zero
);
  logic [OPC_W-1:0] opc;
  logic             is_imm, is_skipz, is_rot, is_btest;

  assign opc      = instr[INSN_W-1:INSN_W-OPC_W];
  assign is_imm   = in_valid && (opc == 6'b110111 || opc == 6'b111000 ||
                    opc == 6'b110100 || opc == 6'b110101 ||
                    opc == 6'b110110 || opc == 6'b111010);
  assign is_skipz = in_valid && (opc == 6'b011010 || opc == 6'b011110);
  assign is_rot   = in_valid && (opc == 6'b010110 || opc == 6'b010101);
  assign is_btest = in_valid && instr[INSN_W-1:INSN_W-2] == 2'b00 && instr[INSN_W-4];

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_w && wr_f)); // R1
  AST_IMM_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
    is_imm |=> wr_w && !wr_f); // R1
  AST_SKIPZ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    is_skipz |=> c_out == $past(c_in) && hc_out == $past(hc_in) && z_out == $past(z_in)); // R5
  AST_SKIPZ_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    is_skipz |=> skip == (result == '0)); // R5
  AST_SKIPZ_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    is_skipz |=> skip == $past(res_zero)); // R5
  AST_ROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    is_rot |=> hc_out == $past(hc_in) && z_out == $past(z_in)); // R6
  AST_BTEST_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    is_btest |=> !wr_w && !wr_f); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_w && !wr_f && !skip); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(c_out) && $stable(z_out)); // R10

endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .c_in      (c_in),
  .hc_in     (hc_in),
  .z_in      (z_in),
  .out_valid (out_valid),
  .result    (result),
  .wr_w      (wr_w),
  .wr_f      (wr_f),
  .c_out     (c_out),
  .hc_out    (hc_out),
  .z_out     (z_out),
  .skip      (skip),
  .res_zero  (res_zero)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [13:0] instr;
  logic [7:0]  w_in, f_in;
  logic        c_in, hc_in, z_in;
  logic        out_valid;
  logic [7:0]  result;
  logic [6:0]  f_addr;
  logic        wr_w, wr_f, c_out, hc_out, z_out, skip;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .w_in(w_in), .f_in(f_in), .c_in(c_in), .hc_in(hc_in), .z_in(z_in),
    .out_valid(out_valid), .result(result), .f_addr(f_addr),
    .wr_w(wr_w), .wr_f(wr_f), .c_out(c_out), .hc_out(hc_out),
    .z_out(z_out), .skip(skip)
  );

  // Packed expectation: {wr_w, wr_f, skip, c, hc, z, result[7:0]}
  function automatic logic [13:0] ref_model(input logic [13:0] ins,
      input logic [7:0] w, input logic [7:0] f,
      input logic c, input logic hc, input logic z);
    logic [7:0] r, imm;
    logic ww, wf, sk, nc, nh, nz, d, rd;
    int s;
    imm = ins[7:0]; d = ins[7];
    ww = 0; wf = 0; sk = 0; nc = c; nh = hc; nz = z; r = 8'h00; rd = 0;
    if (ins[13:12] == 2'b00) begin
      case (ins[11:10])
        2'b00: begin r = f & ~(8'd1 << ins[9:7]); wf = 1; end
        2'b10: begin r = f | (8'd1 << ins[9:7]); wf = 1; end
        2'b01: sk = (f[ins[9:7]] == 1'b0);
        default: sk = (f[ins[9:7]] == 1'b1);
      endcase
    end else begin
      case (ins[13:8])
        6'h1B: begin s = f + w; r = s[7:0]; nc = s > 255;
                 nh = ((f & 15) + (w & 15)) > 15; nz = (r == 0); rd = 1; end
        6'h1C: begin s = f + (255 - w) + 1; r = s[7:0]; nc = s > 255;
                 nh = ((f & 15) + (15 - (w & 15)) + 1) > 15; nz = (r == 0); rd = 1; end
        6'h19: begin r = f + 8'd1; nz = (r == 0); rd = 1; end
        6'h1A: begin r = f + 8'd1; sk = (f == 8'hFF); rd = 1; end
        6'h1D: begin r = f - 8'd1; nz = (r == 0); rd = 1; end
        6'h1E: begin r = f - 8'd1; sk = (f == 8'h01); rd = 1; end
        6'h12: begin r = f & w; nz = (r == 0); rd = 1; end
        6'h13: begin r = f | w; nz = (r == 0); rd = 1; end
        6'h14: begin r = f ^ w; nz = (r == 0); rd = 1; end
        6'h1F: begin r = 8'hFF - f; nz = (r == 0); rd = 1; end
        6'h16: begin r = (f >> 1) | {c, 7'd0}; nc = f[0]; rd = 1; end
        6'h15: begin r = (f << 1) | {7'd0, c}; nc = f[7]; rd = 1; end
        6'h17: begin r = {f[3:0], f[7:4]}; rd = 1; end
        6'h18: begin r = f; nz = (f == 0); rd = 1; end
        6'h11: begin wf = 1; if (d) r = w; else begin r = 0; nz = 1; end end
        6'h10: begin if (d) begin ww = 1; r = 0; nz = 1; end end
        6'h37: begin s = imm + w; r = s[7:0]; nc = s > 255;
                 nh = ((imm & 15) + (w & 15)) > 15; nz = (r == 0); ww = 1; end
        6'h38: begin s = imm + (255 - w) + 1; r = s[7:0]; nc = s > 255;
                 nh = ((imm & 15) + (15 - (w & 15)) + 1) > 15; nz = (r == 0); ww = 1; end
        6'h34: begin r = imm & w; nz = (r == 0); ww = 1; end
        6'h35: begin r = imm | w; nz = (r == 0); ww = 1; end
        6'h36: begin r = imm ^ w; nz = (r == 0); ww = 1; end
        6'h3A: begin r = imm; ww = 1; end
        default: ;
      endcase
      if (rd) begin ww = ~d; wf = d; end
    end
    return {ww, wf, sk, nc, nh, nz, r};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [13:0] ins,
                     input logic [7:0] w, input logic [7:0] f,
                     input logic c, input logic hc, input logic z);
    logic [13:0] e;
    e = ref_model(ins, w, f, c, hc, z);
    instr = ins; w_in = w; f_in = f; c_in = c; hc_in = hc; z_in = z;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(tag, "valid/wr_w/wr_f/skip", {12'd0, out_valid, wr_w, wr_f, skip},
        {12'd0, 1'b1, e[13:11]});
    chk(tag, "c/hc/z", {13'd0, c_out, hc_out, z_out}, {13'd0, e[10:8]});
    if (e[13] | e[12]) chk(tag, "result", {8'd0, result}, {8'd0, e[7:0]});
    if (e[12]) chk(tag, "f_addr", {9'd0, f_addr}, {9'd0, ins[6:0]});
  endtask

  task automatic t_reset;
    in_valid = 1'b1; instr = {6'h37, 8'h55}; w_in = 8'hAA; f_in = 8'h11;
    c_in = 1; hc_in = 1; z_in = 1;
    @(posedge clk); @(negedge clk);
    // R11: all outputs zero while reset is held
    chk("R11", "outputs in reset",
        {out_valid, wr_w, wr_f, skip, c_out, hc_out, z_out, result, f_addr[0]}, 16'd0);
    chk("R11", "f_addr in reset", {9'd0, f_addr}, 16'd0);
    in_valid = 1'b0;
  endtask

  task automatic t_add;
    run("R2", {6'h1B, 1'b0, 7'h10}, 8'h01, 8'h0F, 0, 0, 0);
    run("R2", {6'h1B, 1'b1, 7'h22}, 8'h01, 8'hFF, 0, 0, 0);
    run("R2", {6'h1B, 1'b0, 7'h05}, 8'h80, 8'h80, 0, 1, 0);
    run("R2", {6'h37, 8'hF8}, 8'h08, 8'h00, 0, 0, 1);
    for (int i = 0; i < 24; i++)
      run("R2", {6'h1B, 1'($urandom), 7'($urandom)}, 8'($urandom), 8'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom));
    for (int i = 0; i < 12; i++)
      run("R2", {6'h37, 8'($urandom)}, 8'($urandom), 8'($urandom), 1, 0, 1);
  endtask

  task automatic t_sub;
    run("R3", {6'h1C, 1'b0, 7'h01}, 8'h05, 8'h05, 0, 0, 0);
    run("R3", {6'h1C, 1'b1, 7'h02}, 8'h05, 8'h03, 1, 1, 1);
    run("R3", {6'h1C, 1'b0, 7'h03}, 8'h01, 8'h10, 0, 0, 1);
    run("R3", {6'h38, 8'h20}, 8'h21, 8'h00, 1, 1, 0);
    run("R3", {6'h38, 8'h00}, 8'h00, 8'h00, 0, 0, 0);
    for (int i = 0; i < 24; i++)
      run("R3", {6'h1C, 1'($urandom), 7'($urandom)}, 8'($urandom), 8'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom));
    for (int i = 0; i < 12; i++)
      run("R3", {6'h38, 8'($urandom)}, 8'($urandom), 8'($urandom), 0, 1, 0);
  endtask

  task automatic t_zonly;
    logic [5:0] ops [9] = '{6'h12, 6'h13, 6'h14, 6'h1F, 6'h19, 6'h1D, 6'h18, 6'h34, 6'h35};
    run("R4", {6'h19, 1'b1, 7'h09}, 8'h00, 8'hFF, 1, 1, 0);
    run("R4", {6'h1D, 1'b0, 7'h09}, 8'h00, 8'h01, 0, 1, 0);
    run("R4", {6'h12, 1'b0, 7'h09}, 8'h0F, 8'hF0, 1, 0, 0);
    run("R4", {6'h11, 1'b0, 7'h33}, 8'h77, 8'h66, 1, 1, 0);
    run("R4", {6'h10, 1'b1, 7'h00}, 8'h77, 8'h66, 0, 1, 0);
    run("R4", {6'h36, 8'h5A}, 8'h5A, 8'h00, 1, 1, 0);
    for (int i = 0; i < 36; i++)
      run("R4", {ops[i % 9], 1'($urandom), 7'($urandom)}, 8'($urandom),
          8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic t_skipz;
    run("R5", {6'h1A, 1'b1, 7'h12}, 8'h00, 8'hFF, 1, 0, 0);
    run("R5", {6'h1A, 1'b0, 7'h12}, 8'h00, 8'hFE, 0, 1, 1);
    run("R5", {6'h1E, 1'b1, 7'h12}, 8'h00, 8'h01, 0, 1, 0);
    run("R5", {6'h1E, 1'b0, 7'h12}, 8'h00, 8'h00, 1, 0, 1);
    for (int i = 0; i < 16; i++)
      run("R5", {(i % 2 == 0) ? 6'h1A : 6'h1E, 1'($urandom), 7'($urandom)},
          8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic t_rot;
    run("R6", {6'h16, 1'b1, 7'h04}, 8'h00, 8'h01, 0, 1, 1);
    run("R6", {6'h16, 1'b0, 7'h04}, 8'h00, 8'h00, 1, 0, 0);
    run("R6", {6'h15, 1'b1, 7'h04}, 8'h00, 8'h80, 0, 0, 1);
    run("R6", {6'h15, 1'b0, 7'h04}, 8'h00, 8'h00, 1, 1, 0);
    for (int i = 0; i < 16; i++)
      run("R6", {(i % 2 == 0) ? 6'h16 : 6'h15, 1'($urandom), 7'($urandom)},
          8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic t_noflag;
    run("R7", {6'h17, 1'b1, 7'h2A}, 8'h00, 8'hA5, 1, 0, 1);
    run("R7", {6'h17, 1'b0, 7'h2A}, 8'h00, 8'h00, 0, 1, 0);
    run("R7", {6'h11, 1'b1, 7'h2B}, 8'h00, 8'h99, 1, 1, 0);
    run("R7", {6'h3A, 8'h00}, 8'h44, 8'h99, 0, 0, 0);
    run("R7", {6'h3A, 8'hC3}, 8'h44, 8'h99, 1, 1, 1);
  endtask

  task automatic t_bits;
    for (int b = 0; b < 8; b++) begin
      run("R8", {4'b0000, 3'(b), 7'h15}, 8'h00, 8'hFF, 1, 1, 1);
      run("R8", {4'b0010, 3'(b), 7'h15}, 8'h00, 8'h00, 0, 0, 0);
      run("R8", {4'b0001, 3'(b), 7'h15}, 8'h00, 8'd1 << b, 1, 0, 1);
      run("R8", {4'b0001, 3'(b), 7'h15}, 8'h00, ~(8'd1 << b), 0, 1, 0);
      run("R8", {4'b0011, 3'(b), 7'h15}, 8'h00, 8'd1 << b, 0, 1, 1);
      run("R8", {4'b0011, 3'(b), 7'h15}, 8'h00, ~(8'd1 << b), 1, 0, 0);
    end
  endtask

  task automatic t_unused;
    run("R9", {6'h10, 8'h02}, 8'h12, 8'h34, 1, 0, 1);
    run("R9", {6'h10, 8'h09}, 8'h12, 8'h00, 0, 1, 0);
    run("R9", {6'h25, 8'hFF}, 8'h00, 8'h00, 1, 1, 1);
    run("R9", {6'h31, 8'h00}, 8'h00, 8'h00, 0, 0, 0);
    run("R9", {6'h39, 8'h00}, 8'hFF, 8'h01, 1, 0, 0);
    run("R9", {6'h3F, 8'hFF}, 8'hFF, 8'hFF, 0, 1, 1);
  endtask

  task automatic t_dest;
    logic [5:0] ops [6] = '{6'h1B, 6'h1C, 6'h13, 6'h17, 6'h16, 6'h18};
    for (int i = 0; i < 24; i++)
      run("R1", {ops[i % 6], 1'(i / 6), 7'($urandom)}, 8'($urandom),
          8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic t_idle;
    logic [7:0] r0;
    logic [2:0] fl0;
    run("R10", {6'h37, 8'h33}, 8'h11, 8'h00, 0, 0, 0);
    r0 = result; fl0 = {c_out, hc_out, z_out};
    in_valid = 1'b0; instr = {6'h1C, 1'b1, 7'h7F}; w_in = 8'hFF; f_in = 8'h00;
    c_in = 1; hc_in = 1; z_in = 1;
    @(posedge clk); @(negedge clk);
    chk("R10", "idle valid/wr/skip", {12'd0, out_valid, wr_w, wr_f, skip}, 16'd0);
    chk("R10", "idle hold result/flags", {5'd0, result, c_out, hc_out, z_out},
        {5'd0, r0, fl0});
  endtask

  initial begin
    #800us;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; w_in = '0; f_in = '0;
    c_in = 0; hc_in = 0; z_in = 0;
    @(negedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_add;
    t_sub;
    t_zonly;
    t_skipz;
    t_rot;
    t_noflag;
    t_bits;
    t_unused;
    t_dest;
    t_idle;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule